// File: doc/BRIEF.md
# Receive Cell Buffer with Cell-Level Availability

This block sits between a receive framer and an ATM layer device. The framer pushes 16-bit cell words into it, and marks the first word of each cell. The block keeps up to four cells. The reader pulls them out over a UTOPIA-style receive bus, which carries an active-low read enable, a cell-available flag, a data bus and a start-of-cell strobe. The cell-available flag is raised only when a whole cell is ready and has not been started. A reader that sees the flag drop may still finish the cell it is reading.

A small two-address register interface gives software three things. It can flush the buffer without a device reset. It can see full and empty. It can enable three events as interrupts: overrun, underrun and a change of the cell-available flag. The event status bits clear when they are read. Everything runs on one clock.

Top module: `rx_cell_buffer`

## Requirements
- R1: `cellAvail` is high exactly when at least one complete cell is stored that the reader has not started. It changes right after the edge that stores the last word of a cell, and right after the edge that starts a read. A partly written cell never raises it.
- R2: `rdEnN` is active low. Suppose a rising edge sees `rdEnN` low, no cell being read and `cellAvail` high. Right after that edge, `rdData` shows word 0 of the oldest stored cell and `rdSoc` is 1.
- R3: While a cell is in progress, each edge with `rdEnN` low delivers the next word, words 1 to 26, in order, with `rdSoc` at 0. This holds even when `cellAvail` is low. An edge with `rdEnN` high keeps `rdData` unchanged and sets `rdSoc` to 0.
- R4: A cell is 27 words of 16 bits. An edge with `wrValid` and `wrSoc` both high starts a cell. Words with `wrValid` high and `wrSoc` low extend the cell that is being written. Such words are thrown away when no accepted cell is being written. Cells are delivered in the order they were written.
- R5: The buffer holds 4 cells. Reading address 1 gives bit 1 = full (4 complete cells stored) and bit 0 = empty (no word stored, complete or partial). Bits 7 to 2 read 0.
- R6: A cell start that arrives while the buffer is full drops that entire cell and sets overrun status (address 0, bit 3).
- R7: An edge with `rdEnN` low, no cell in progress and `cellAvail` low delivers nothing. `rdSoc` stays 0, and underrun status (address 0, bit 4) is set.
- R8: The availability-change status (address 0, bit 5) is set on the edge after any edge that changed `cellAvail`.
- R9: Reading address 0 clears the three status bits on that edge. An event on that same edge still sets its bit. Writing address 0 has no effect on the status bits.
- R10: Writing 1 to bit 6 of address 0 throws away every stored and partly stored cell and any read in progress. After that edge, `cellAvail` is 0 and the empty flag is 1. The same write loads the enables from bits 2..0, and the status bits are kept. Bit 6 always reads 0.
- R11: The enables sit in address 0 bits 0 (overrun), 1 (underrun) and 2 (availability change). `irq` is the OR, over the three events, of the status bit ANDed with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for framer side, bus side and registers |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Framer word strobe |
| wrSoc | input | 1 | Marks the word as word 0 of a new cell |
| wrData | input | 16 | Framer cell word |
| rdEnN | input | 1 | Active-low read enable from the ATM layer |
| cellAvail | output | 1 | A complete, unstarted cell is stored |
| rdData | output | 16 | Cell word delivered to the reader |
| rdSoc | output | 1 | High with word 0 of each delivered cell |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (clears status at address 0) |
| regAddr | input | 1 | 0: enable/status/flush, 1: fill status |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational from regAddr |
| irq | output | 1 | Enabled-event interrupt |

## Verification
The assertions assume a few things about the inputs. `rdSoc` may only follow an edge where the enable was low. A flush leaves the buffer empty on the next cycle. `irq` stays low while no enable is set. `rdEnN` is assumed to be held high during reset. The bench holds it high during reset, and it changes every input only on falling clock edges. It also never asks for a read register access and a write register access in the same cycle. Write and read phases alternate in the bench, so the expected `cellAvail` and FIFO fill can be worked out from a count of stored cells and a queue of cell labels.

// File: rtl/rxcb_pkg.sv
package rxcb_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic store;     // write wrData into the write slot
    logic fetch;     // load the read slot into the output register
    logic fetchSoc;  // the fetched word is word 0 of a cell
  } dpStrobe_t;

  // address-0 register layout
  localparam int EN_OVR_BIT  = 0;
  localparam int EN_UND_BIT  = 1;
  localparam int EN_CAC_BIT  = 2;
  localparam int ST_LSB      = 3;
  localparam int FLUSH_BIT   = 6;
  localparam int EVT_N       = 3;
endpackage

// File: rtl/rxcb_datapath.sv
module rxcb_datapath
  import rxcb_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SLOTS  = 108,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              rdSoc
);
  logic [WORD_W-1:0] cellMem [SLOTS];

  always_ff @(posedge clk) begin
    if (stb.store) cellMem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      rdSoc  <= 1'b0;
    end else begin
      rdSoc <= stb.fetch & stb.fetchSoc;
      if (stb.fetch) rdData <= cellMem[rdAddr];
    end
  end
endmodule

// File: rtl/rxcb_control.sv
module rxcb_control
  import rxcb_pkg::*;
#(
  parameter int CELL_WORDS  = 27,
  parameter int DEPTH_CELLS = 4,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              wrSoc,
  input  logic              rdEnN,
  input  logic              flush,
  output dpStrobe_t         stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              cellAvail,
  output logic              full,
  output logic              empty,
  output logic              ovrEvt,
  output logic              undEvt
);
  localparam int WIDX_W = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1;
  localparam int CIDX_W = (DEPTH_CELLS > 1) ? $clog2(DEPTH_CELLS) : 1;
  localparam int CNT_W  = $clog2(DEPTH_CELLS + 1);
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(CELL_WORDS - 1);
  localparam logic [CIDX_W-1:0] LAST_CELL = CIDX_W'(DEPTH_CELLS - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH_CELLS);

  function automatic logic [CIDX_W-1:0] nextCell(input logic [CIDX_W-1:0] c);
    return (c == LAST_CELL) ? '0 : c + CIDX_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] slotAddr(input logic [CIDX_W-1:0] c,
                                                 input logic [WIDX_W-1:0] w);
    return ADDR_W'(c) * ADDR_W'(CELL_WORDS) + ADDR_W'(w);
  endfunction

  logic              wrActive, rdActive;
  logic [CIDX_W-1:0] wrCell, rdCell;
  logic [WIDX_W-1:0] wrWord, rdWord;
  logic [CNT_W-1:0]  cellCnt, availCnt;

  logic rdReq, startWr, contWr, startRd, contRd, commit, finish;
  logic [WIDX_W-1:0] wrIdx, rdIdx;

  always_comb begin
    availCnt  = cellCnt - CNT_W'(rdActive);
    cellAvail = (availCnt != '0);
    full      = (cellCnt == FULL_CNT);
    empty     = (cellCnt == '0) && !wrActive;

    startWr = !flush && wrValid && wrSoc && (wrActive || !full);
    contWr  = !flush && wrValid && !wrSoc && wrActive;
    ovrEvt  = !flush && wrValid && wrSoc && !wrActive && full;
    wrIdx   = startWr ? '0 : wrWord;
    commit  = (startWr || contWr) && (wrIdx == LAST_WORD);

    rdReq   = !rdEnN && !flush;
    contRd  = rdReq && rdActive;
    startRd = rdReq && !rdActive && cellAvail;
    undEvt  = rdReq && !rdActive && !cellAvail;
    rdIdx   = startRd ? '0 : rdWord;
    finish  = (startRd || contRd) && (rdIdx == LAST_WORD);

    stb.store    = startWr || contWr;
    stb.fetch    = startRd || contRd;
    stb.fetchSoc = startRd;
    wrAddr = slotAddr(wrCell, wrIdx);
    rdAddr = slotAddr(rdCell, rdIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActive <= 1'b0;
      rdActive <= 1'b0;
      wrCell   <= '0;
      rdCell   <= '0;
      wrWord   <= '0;
      rdWord   <= '0;
      cellCnt  <= '0;
    end else if (flush) begin
      wrActive <= 1'b0;
      rdActive <= 1'b0;
      wrCell   <= '0;
      rdCell   <= '0;
      wrWord   <= '0;
      rdWord   <= '0;
      cellCnt  <= '0;
    end else begin
      if (commit) begin
        wrActive <= 1'b0;
        wrWord   <= '0;
        wrCell   <= nextCell(wrCell);
      end else if (startWr || contWr) begin
        wrActive <= 1'b1;
        wrWord   <= wrIdx + WIDX_W'(1);
      end
      if (finish) begin
        rdActive <= 1'b0;
        rdWord   <= '0;
        rdCell   <= nextCell(rdCell);
      end else if (startRd || contRd) begin
        rdActive <= 1'b1;
        rdWord   <= rdIdx + WIDX_W'(1);
      end
      cellCnt <= cellCnt + CNT_W'(commit) - CNT_W'(finish);
    end
  end
endmodule

// File: rtl/rxcb_regs.sv
module rxcb_regs
  import rxcb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic       regRd,
  input  logic       regAddr,
  input  logic [7:0] regWdata,
  input  logic       full,
  input  logic       empty,
  input  logic       cellAvail,
  input  logic       ovrEvt,
  input  logic       undEvt,
  output logic       flush,
  output logic [EVT_N-1:0] intEn,
  output logic [7:0] regRdata,
  output logic       irq
);
  logic [EVT_N-1:0] intSt, evt;
  logic availQ, rdClr;
  logic unusedBits;

  assign unusedBits = ^{regWdata[7], regWdata[5:3]};
  assign flush = regWr && !regAddr && regWdata[FLUSH_BIT];
  assign rdClr = regRd && !regAddr;

  always_comb begin
    evt = '0;
    evt[EN_OVR_BIT] = ovrEvt;
    evt[EN_UND_BIT] = undEvt;
    evt[EN_CAC_BIT] = cellAvail ^ availQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn  <= '0;
      intSt  <= '0;
      availQ <= 1'b0;
    end else begin
      availQ <= cellAvail;
      intSt  <= (intSt & ~{EVT_N{rdClr}}) | evt;
      if (regWr && !regAddr) intEn <= regWdata[EVT_N-1:0];
    end
  end

  always_comb begin
    regRdata = '0;
    if (!regAddr) begin
      regRdata[EVT_N-1:0]           = intEn;
      regRdata[ST_LSB +: EVT_N]     = intSt;
    end else begin
      regRdata[1] = full;
      regRdata[0] = empty;
    end
  end

  assign irq = |(intSt & intEn);
endmodule

// File: rtl/rx_cell_buffer.sv
module rx_cell_buffer
  import rxcb_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int CELL_WORDS  = 27,
  parameter int DEPTH_CELLS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              wrSoc,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEnN,
  output logic              cellAvail,
  output logic [WORD_W-1:0] rdData,
  output logic              rdSoc,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              irq
);
  localparam int SLOTS  = CELL_WORDS * DEPTH_CELLS;
  localparam int ADDR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  dpStrobe_t         stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic fullW, emptyW, flushW, ovrEvt, undEvt;
  logic [EVT_N-1:0] intEnW;

  rxcb_control #(
    .CELL_WORDS(CELL_WORDS), .DEPTH_CELLS(DEPTH_CELLS), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrSoc(wrSoc), .rdEnN(rdEnN),
    .flush(flushW), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .cellAvail(cellAvail), .full(fullW), .empty(emptyW),
    .ovrEvt(ovrEvt), .undEvt(undEvt)
  );

  rxcb_datapath #(
    .WORD_W(WORD_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .rdSoc(rdSoc)
  );

  rxcb_regs u_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .full(fullW), .empty(emptyW), .cellAvail(cellAvail),
    .ovrEvt(ovrEvt), .undEvt(undEvt), .flush(flushW), .intEn(intEnW),
    .regRdata(regRdata), .irq(irq)
  );
endmodule

// File: rtl/rxcb_checker.sv
module rxcb_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rdEnN,
  input logic       rdSoc,
  input logic       cellAvail,
  input logic       irq,
  input logic       full,
  input logic       empty,
  input logic       flush,
  input logic [2:0] intEn
);
  // R1: availability implies stored data
  p_avail_has_data_r1: assert property (@(posedge clk) disable iff (!rstN)
    cellAvail |-> !empty);

  // R2: a start-of-cell word only follows an enabled edge
  p_soc_after_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdSoc |-> $past(!rdEnN));

  // R3: an idle edge never produces a start-of-cell
  p_idle_edge_no_soc_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdEnN |=> !rdSoc);

  // R5: full and empty are exclusive
  p_full_excl_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

  // R10: a flush leaves nothing behind
  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!cellAvail && empty));

  // R11: no interrupt while every enable is off
  p_irq_needs_enable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (intEn == 3'b000) |-> !irq);
endmodule

bind rx_cell_buffer rxcb_checker u_chk (
  .clk(clk), .rstN(rstN), .rdEnN(rdEnN), .rdSoc(rdSoc), .cellAvail(cellAvail),
  .irq(irq), .full(fullW), .empty(emptyW), .flush(flushW), .intEn(intEnW)
);

// File: tb/sim_rx_cell_buffer.sv
module sim_rx_cell_buffer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0, wrSoc = 1'b0, rdEnN = 1'b1;
  logic [15:0] wrData = '0;
  logic regWr = 1'b0, regRd = 1'b0, regAddr = 1'b0;
  logic [7:0] regWdata = '0;
  logic cellAvail, rdSoc, irq;
  logic [15:0] rdData;
  logic [7:0] regRdata;

  int checks = 0;
  int errors = 0;
  int stored = 0;
  int expIds[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_cell_buffer u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrSoc(wrSoc), .wrData(wrData),
    .rdEnN(rdEnN), .cellAvail(cellAvail), .rdData(rdData), .rdSoc(rdSoc),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regCheck(input bit addr, input int mask, input int exp, input string tag);
    regAddr = addr;
    regRd = 1'b1;
    #1;
    chk(tag, int'(regRdata) & mask, exp);
    tick();
    regRd = 1'b0;
  endtask

  task automatic regClear();
    regAddr = 1'b0;
    regRd = 1'b1;
    tick();
    regRd = 1'b0;
  endtask

  task automatic regWrite(input int data);
    regAddr = 1'b0;
    regWdata = 8'(data);
    regWr = 1'b1;
    tick();
    regWr = 1'b0;
  endtask

  task automatic writeCell(input int id);
    bit drop;
    drop = (stored == 4);
    for (int w = 0; w < 27; w++) begin
      if (w == 26) chk("R1 partial cell not available", int'(cellAvail), int'(stored > 0));
      wrValid = 1'b1;
      wrSoc = (w == 0);
      wrData = 16'((id << 8) | w);
      tick();
    end
    wrValid = 1'b0;
    wrSoc = 1'b0;
    if (!drop) begin
      stored++;
      expIds.push_back(id);
    end
    chk("R1 complete cell available", int'(cellAvail), 1);
  endtask

  task automatic readCell(input int pause);
    int id;
    logic [15:0] held;
    id = expIds.pop_front();
    for (int w = 0; w < 27; w++) begin
      rdEnN = 1'b0;
      tick();
      chk("R2 R3 R4 word", int'(rdData), (id << 8) | w);
      chk("R2 R3 start mark", int'(rdSoc), int'(w == 0));
      if (w == 0) chk("R1 avail after start", int'(cellAvail), int'(stored > 1));
      if (pause > 0 && (w % pause) == pause - 1 && w < 26) begin
        rdEnN = 1'b1;
        held = rdData;
        tick();
        chk("R3 hold on idle edge", int'(rdData), int'(held));
        chk("R3 no mark on idle edge", int'(rdSoc), 0);
      end
    end
    rdEnN = 1'b1;
    stored--;
  endtask

  initial begin
    int id;
    id = 1;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk("R1 reset avail", int'(cellAvail), 0);
    chk("R2 reset mark", int'(rdSoc), 0);
    chk("R11 reset irq", int'(irq), 0);
    regCheck(1'b1, 'hFF, 'h01, "R5 reset status");
    regCheck(1'b0, 'hFF, 'h00, "R9 reset status");

    // single cell, availability event, clear on read
    writeCell(id++);
    tick();
    regCheck(1'b0, 'h20, 'h20, "R8 availability change");
    regCheck(1'b0, 'hFF, 'h00, "R9 cleared by read");
    readCell(0);
    regWrite('h38);
    regClear();
    regWrite('h38);
    regCheck(1'b0, 'hFF, 'h00, "R9 status write ignored");

    // fill sweep with overrun
    regWrite('h01);
    for (int n = 1; n <= 4; n++) begin
      writeCell(id++);
      regCheck(1'b1, 'hFF, (n == 4) ? 'h02 : 'h00, "R5 fill level");
    end
    regClear();
    writeCell(id++);
    chk("R11 overrun irq", int'(irq), 1);
    regCheck(1'b0, 'h08, 'h08, "R6 overrun status");
    chk("R11 irq cleared", int'(irq), 0);
    regCheck(1'b1, 'hFF, 'h02, "R6 still full");
    for (int k = 0; k < 4; k++) begin
      readCell(k + 1);
      regCheck(1'b1, 'hFF, (stored == 0) ? 'h01 : 'h00, "R5 drain level");
    end

    // underrun
    regClear();
    rdEnN = 1'b0;
    tick();
    rdEnN = 1'b1;
    chk("R7 nothing delivered", int'(rdSoc), 0);
    chk("R11 masked underrun", int'(irq), 0);
    regWrite('h02);
    chk("R11 underrun irq", int'(irq), 1);
    regCheck(1'b0, 'h10, 'h10, "R7 underrun status");
    chk("R11 irq after clear", int'(irq), 0);

    // orphan words
    for (int w = 0; w < 3; w++) begin
      wrValid = 1'b1;
      wrSoc = 1'b0;
      wrData = 16'hDEAD;
      tick();
    end
    wrValid = 1'b0;
    regCheck(1'b1, 'hFF, 'h01, "R4 orphan words dropped");

    // flush with stored and partial cells
    writeCell(id++);
    writeCell(id++);
    for (int w = 0; w < 5; w++) begin
      wrValid = 1'b1;
      wrSoc = (w == 0);
      wrData = 16'(w);
      tick();
    end
    wrValid = 1'b0;
    wrSoc = 1'b0;
    regClear();
    regWrite('h45);
    chk("R10 avail after flush", int'(cellAvail), 0);
    regCheck(1'b1, 'hFF, 'h01, "R10 empty after flush");
    regCheck(1'b0, 'hC7, 'h05, "R10 enables kept");
    stored = 0;
    expIds.delete();
    writeCell(id++);
    readCell(2);
    regCheck(1'b1, 'hFF, 'h01, "R10 clean after flush");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule